// File: doc/BRIEF.md
# Seven-Source Interrupt Gatherer

This block merges seven event sources into a single interrupt request toward a host. Four sources are handshake request lines from two parallel ports. The other three are counter/timer outputs, and each of these can be set to trigger on its output going high or on its output going low. Every source passes through a two-flop synchroniser and an edge detector. An edge in the chosen direction sets a sticky pending flag, but only while that source's enable bit is set.

Software works through a byte-wide register bus with a 4-bit offset. It writes an enable register and reads a read-only status register that uses the same bit positions. It also writes two routing registers that hold the trigger-level bits for the counters. Software acknowledges a source by writing its enable bit to 0 and then back to 1. The request output is registered and stays high while any enabled pending flag is set.

Top module: `irq_gather`

## Requirements
- R1: After reset, the enable register, the status register, all three level bits and `irq_req` are 0.
- R2: Offset 0xC is the enable register. Bits 6:0 can be written and read back, and bit 7 always reads 0. Bit 0 is handshake 0, bit 1 is handshake 1, bit 2 is handshake 2, bit 3 is handshake 3, bit 4 is counter 0, bit 5 is counter 1 and bit 6 is counter 2.
- R3: A rising edge on `hs_req[n]` sets status bit n while enable bit n is 1. If the input settles before clock edge k, the flag can be read after edge k+2. The flag stays set after the input returns low.
- R4: Counter j fires on a rising edge of `tmr_out[j]` when its level bit is 1 and on a falling edge when it is 0. An edge in the other direction is ignored. Counter 0's level bit is bit 6 at offset 0xE. Counter 1's is bit 6 and counter 2's is bit 7 at offset 0xF. All other bits at these two offsets read 0.
- R5: An event on a source whose enable bit is 0 is not recorded. A status bit reads 0 whenever its enable bit is 0.
- R6: Writing an enable bit to 0 clears its status bit. Writing it back to 1 re-arms the source with no pending flag.
- R7: `irq_req` goes high one clock after any enabled status bit is set. It goes low one clock after the last one clears.
- R8: The status register at offset 0xD is read-only. A write to it changes nothing.
- R9: When an event and an enable write meet in the same cycle, the written enable value decides the outcome. Writing 0 drops the event, and writing 1 records it.
- R10: Offsets 0x0 to 0xB read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| hs_req | input | 4 | Handshake request lines, active on a rising edge |
| tmr_out | input | 3 | Counter/timer outputs |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A source edge and a software write to the enable register can fall in the same cycle. The outcome in that cycle decides whether an acknowledge loses an event. The bench raises a handshake line two clocks before an enable write, so the detected edge reaches the pending logic in exactly the cycle the write lands. This is done once with a write that clears the bit and once with a write that sets it. The status read afterwards must show the flag dropped in the first case and kept in the second, as R9 requires.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned REG_AW  = 4;
  localparam int unsigned REG_DW  = 8;
  localparam int unsigned NUM_HS  = 4;
  localparam int unsigned NUM_TMR = 3;
  localparam int unsigned NUM_SRC = NUM_HS + NUM_TMR;

  localparam logic [REG_AW-1:0] OFS_ENA    = 4'hC;
  localparam logic [REG_AW-1:0] OFS_STAT   = 4'hD;
  localparam logic [REG_AW-1:0] OFS_CLKRT  = 4'hE;
  localparam logic [REG_AW-1:0] OFS_GATERT = 4'hF;

  // bit positions of the level-select fields inside the routing registers
  localparam int unsigned LVL0_BIT = 6;  // counter 0 in OFS_CLKRT
  localparam int unsigned LVL1_BIT = 6;  // counter 1 in OFS_GATERT
  localparam int unsigned LVL2_BIT = 7;  // counter 2 in OFS_GATERT
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic level_i,
  output logic event_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q, sync_d;
  logic         prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[MSB-1:0], src_i};
    prev_d = sync_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // level_i = 1: low-to-high transition, level_i = 0: high-to-low transition
  always_comb begin
    if (level_i) event_o = sync_q[MSB] & ~prev_q;
    else         event_o = ~sync_q[MSB] & prev_q;
  end

  // R3/R4: an edge produces a single-cycle event while the level is steady
  p_event_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> (!event_o || !$stable(level_i)));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_gather_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] en_q_o,
  output logic [NUM_SRC-1:0] en_d_o,
  output logic [NUM_TMR-1:0] lvl_o,
  output logic [REG_DW-1:0] rd_data_o
);
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_TMR-1:0] lvl_q, lvl_d;
  logic               wr_ena, wr_clk, wr_gate;

  always_comb begin
    wr_ena  = wr_en_i && (addr_i == OFS_ENA);
    wr_clk  = wr_en_i && (addr_i == OFS_CLKRT);
    wr_gate = wr_en_i && (addr_i == OFS_GATERT);
    en_d    = en_q;
    lvl_d   = lvl_q;
    if (wr_ena) en_d = wr_data_i[NUM_SRC-1:0];
    if (wr_clk) lvl_d[0] = wr_data_i[LVL0_BIT];
    if (wr_gate) begin
      lvl_d[1] = wr_data_i[LVL1_BIT];
      lvl_d[2] = wr_data_i[LVL2_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_ena)            en_q  <= en_d;
      if (wr_clk || wr_gate) lvl_q <= lvl_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      OFS_ENA:    rd_data_o[NUM_SRC-1:0] = en_q;
      OFS_STAT:   rd_data_o[NUM_SRC-1:0] = status_i;
      OFS_CLKRT:  rd_data_o[LVL0_BIT]    = lvl_q[0];
      OFS_GATERT: begin
        rd_data_o[LVL1_BIT] = lvl_q[1];
        rd_data_o[LVL2_BIT] = lvl_q[2];
      end
      default:    rd_data_o = '0;
    endcase
  end

  assign en_q_o = en_q;
  assign en_d_o = en_d;
  assign lvl_o  = lvl_q;

  // R2: an enable write takes effect on the next edge
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_ENA) |=> (en_q == $past(wr_data_i[NUM_SRC-1:0])));
  // R2/R8: without an enable write, the enables do not move
  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == OFS_ENA) |=> $stable(en_q));
endmodule

// File: rtl/irq_pend.sv
module irq_pend
  import irq_gather_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] en_q_i,
  input  logic [NUM_SRC-1:0] en_d_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic               irq_q, irq_d;

  always_comb begin
    // the enable value being written this cycle gates both new events and old flags
    status_d = en_d_i & (status_q | event_i);
    irq_d    = |(status_q & en_q_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R5: no pending flag without its enable
  p_no_flag_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~en_q_i) == '0);
  // R3: a flag whose enable stays set is sticky
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q & en_d_i) & ~status_q) == '0));
  // R7: request follows pending flags one clock later
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & en_q_i)) |=> irq_q);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & en_q_i)) |=> !irq_q);
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wr_data,
  output logic [REG_DW-1:0] reg_rd_data,
  input  logic [NUM_HS-1:0] hs_req,
  input  logic [NUM_TMR-1:0] tmr_out,
  output logic              irq_req
);
  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] events;
  logic [NUM_SRC-1:0] en_q, en_d, status;
  logic [NUM_TMR-1:0] lvl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  for (genvar h = 0; h < NUM_HS; h++) begin : g_hs
    irq_src_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src_i   (hs_req[h]),
      .level_i (1'b1),
      .event_o (events[h])
    );
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    irq_src_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src_i   (tmr_out[t]),
      .level_i (lvl[t]),
      .event_o (events[NUM_HS+t])
    );
  end

  irq_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (reg_wr_en),
    .addr_i    (reg_addr),
    .wr_data_i (reg_wr_data),
    .status_i  (status),
    .en_q_o    (en_q),
    .en_d_o    (en_d),
    .lvl_o     (lvl),
    .rd_data_o (reg_rd_data)
  );

  irq_pend i_pend (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .event_i  (events),
    .en_q_i   (en_q),
    .en_d_i   (en_d),
    .status_o (status),
    .irq_o    (irq_req)
  );

  // R2: reserved bit 7 of enable and status reads 0
  p_rsvd_bit_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr == OFS_ENA || reg_addr == OFS_STAT) |-> !reg_rd_data[7]);
  // R10: offsets below the enable register read 0
  p_low_ofs_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr < OFS_ENA) |-> (reg_rd_data == '0));
endmodule

// File: tb/test_irq_gather.sv
module test_irq_gather;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [3:0] reg_addr;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data;
  logic [3:0] hs_req;
  logic [2:0] tmr_out;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [3:0] A_ENA = 4'hC, A_STAT = 4'hD, A_CLK = 4'hE, A_GATE = 4'hF;

  always #10 clk = ~clk;

  irq_gather i_irq_gather (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .hs_req(hs_req),
    .tmr_out(tmr_out), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(A_ENA, d);  check("R1 enable after reset", d, 8'h00);
    rd(A_STAT, d); check("R1 status after reset", d, 8'h00);
    rd(A_CLK, d);  check("R1 clk routing after reset", d, 8'h00);
    rd(A_GATE, d); check("R1 gate routing after reset", d, 8'h00);
    check("R1 irq after reset", {7'b0, irq_req}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(A_ENA, 8'hFF);  rd(A_ENA, d);  check("R2 enable readback, bit7 zero", d, 8'h7F);
    wr(A_ENA, 8'h2A);  rd(A_ENA, d);  check("R2 enable pattern", d, 8'h2A);
    wr(A_CLK, 8'hFF);  rd(A_CLK, d);  check("R4 clk routing level bit only", d, 8'h40);
    wr(A_GATE, 8'h7F); rd(A_GATE, d); check("R4 gate routing bit6 only", d, 8'h40);
    rd(4'h3, d);       check("R10 low offset reads zero", d, 8'h00);
    rd(4'hB, d);       check("R10 offset 0xB reads zero", d, 8'h00);
    wr(A_ENA, 8'h00);
  endtask

  task automatic t_hs_latency;
    wr(A_ENA, 8'h01);
    reg_addr = A_STAT;
    @(negedge clk); hs_req[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 status not yet set at k+1", reg_rd_data, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R3 status set after k+2", reg_rd_data, 8'h01);
    check("R7 irq still low same cycle", {7'b0, irq_req}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R7 irq high one clock later", {7'b0, irq_req}, 8'h01);
    hs_req[0] = 1'b0;
    idle(5);
    check("R3 flag sticky after input drops", reg_rd_data, 8'h01);
  endtask

  task automatic t_status_ro;
    logic [7:0] d;
    wr(A_STAT, 8'h00); rd(A_STAT, d); check("R8 status write ignored", d, 8'h01);
    rd(A_ENA, d); check("R8 status write leaves enable", d, 8'h01);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(A_ENA, 8'h00);
    check("R7 irq still high right after clear", {7'b0, irq_req}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R7 irq low one clock after clear", {7'b0, irq_req}, 8'h00);
    rd(A_STAT, d); check("R6 status cleared by enable drop", d, 8'h00);
    wr(A_ENA, 8'h01);
    rd(A_STAT, d); check("R6 re-armed without pending", d, 8'h00);
    check("R6 irq low after re-arm", {7'b0, irq_req}, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(A_ENA, 8'h00);
    @(negedge clk); hs_req[1] = 1'b1;
    idle(5);
    hs_req[1] = 1'b0;
    idle(5);
    wr(A_ENA, 8'h02);
    rd(A_STAT, d); check("R5 disabled event not recorded", d, 8'h00);
    check("R5 irq stays low", {7'b0, irq_req}, 8'h00);
    wr(A_ENA, 8'h00);
  endtask

  task automatic t_tmr_levels;
    logic [7:0] d;
    wr(A_CLK, 8'h40);   // counter 0 fires high
    wr(A_GATE, 8'h80);  // counter 1 fires low, counter 2 fires high
    wr(A_ENA, 8'h70);
    @(negedge clk); tmr_out[0] = 1'b1; tmr_out[1] = 1'b1;
    idle(5);
    rd(A_STAT, d); check("R4 counter0 rising, counter1 rising ignored", d, 8'h10);
    @(negedge clk); tmr_out[1] = 1'b0;
    idle(5);
    rd(A_STAT, d); check("R4 counter1 falling fires", d, 8'h30);
    @(negedge clk); tmr_out[2] = 1'b1; tmr_out[0] = 1'b0;
    idle(5);
    rd(A_STAT, d); check("R4 counter2 rising fires", d, 8'h70);
    check("R7 irq high for counter flags", {7'b0, irq_req}, 8'h01);
    wr(A_ENA, 8'h00);
    rd(A_STAT, d); check("R6 counter flags cleared", d, 8'h00);
    tmr_out = 3'b000;
    idle(5);
  endtask

  task automatic collide_hs2(input logic [7:0] ena_val);
    @(negedge clk); hs_req[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = A_ENA; reg_wr_data = ena_val; reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(A_ENA, 8'h04);
    collide_hs2(8'h00);
    idle(3);
    rd(A_STAT, d); check("R9 clearing write drops same-cycle event", d, 8'h00);
    wr(A_ENA, 8'h04);
    rd(A_STAT, d); check("R9 nothing pending after re-enable", d, 8'h00);
    wr(A_ENA, 8'h00);
    @(negedge clk); hs_req[2] = 1'b0;
    idle(5);
    collide_hs2(8'h04);
    idle(3);
    rd(A_STAT, d); check("R9 setting write keeps same-cycle event", d, 8'h04);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 4'h0; reg_wr_data = 8'h00;
    hs_req = 4'h0; tmr_out = 3'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_hs_latency();
    t_status_ro();
    t_clear();
    t_disabled();
    t_tmr_levels();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule